// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the CPU clock into the time base of a CAN controller. A programmable divider makes time quanta. A segment sequencer groups the quanta into bit periods. Each bit is one sync quantum, then a first phase of `BS1+1` quanta, then a second phase of `BS2+1` quanta. The block raises a strobe on every quantum, at the sample point (the end of the first phase), and on the last quantum of every bit.

Edge logic outside the block reports phase errors, counted in quanta, through a resynchronization request. A positive error stretches the first phase and a negative error trims the second phase. The correction is always limited to the programmed jump width, and only the first request in a bit is taken.

Configuration is two byte-wide registers. Both can be written only while the controller sits in standby, so a faulty write during traffic cannot bend the bit timing.

Top module: `can_bit_timer`

## Requirements
- R1: After reset both configuration registers hold 00h (divider 1, jump limit 1, BS1 = BS2 = 0), all strobes are low, and a released controller produces a bit every 3 clock cycles.
- R2: Register select 0 holds the jump width in bits 7:6 and the divider value BRP in bits 5:0. `tq_tick` pulses once every BRP+1 clock cycles.
- R3: Register select 1 holds BS1 in bits 3:0 and BS2 in bits 6:4. With no correction, a bit lasts BS1+BS2+3 quanta, so `bit_tick` repeats every (BS1+BS2+3)·(BRP+1) cycles.
- R4: `sample_tick` pulses (BS1+2)·(BRP+1) cycles after the previous bit boundary.
- R5: A request with a positive error e lengthens the first phase of the current bit by min(e, RJW+1) quanta, so the sample point and the bit boundary both move later.
- R6: A request with a negative error e trims the second phase by min(|e|, RJW+1) quanta. The second phase never drops below one quantum, and the sample point stays where it was.
- R7: Only the first request with a non-zero error in a bit period is applied. Later requests in that bit have no effect.
- R8: Writes made while `standby` is low change neither register, and the bit timing stays as it was.
- R9: While `standby` is high no strobe is raised. When `standby` falls, timing restarts at the sync quantum, and the first `bit_tick` comes (BS1+BS2+3)·(BRP+1) cycles after the first clock edge that sees `standby` low.
- R10: `bit_tick` is always raised together with `tq_tick`, and never in the same cycle as `sample_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| standby | input | 1 | High while the controller is in standby; holds timing idle |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = divider/jump register, 1 = segment register |
| cfg_wdata | input | 8 | Write data |
| resync_req | input | 1 | Phase error report valid |
| resync_err | input | 5 | Signed phase error in quanta |
| tq_tick | output | 1 | One-cycle strobe per time quantum |
| sample_tick | output | 1 | Strobe at the end of the first phase |
| bit_tick | output | 1 | Strobe on the last quantum of each bit |

## Verification
A wrong divider count shows up within one quantum as a bad spacing of `tq_tick`. A sequencer that enters the wrong segment moves `sample_tick` or `bit_tick` within the same bit period, and the bench measures both positions in cycles from the previous boundary. A stale correction left over from an earlier bit, or a second correction accepted in one bit, appears as a wrong length of that bit or of the next one. A register that takes a write outside standby changes the very next bit length.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;
endpackage

// File: rtl/can_tq_prescaler.sv
module can_tq_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [BRP_W-1:0] brp,
  output logic             adv,
  output logic             tq_tick
);
  logic [BRP_W-1:0] div_cnt;

  assign adv = !hold && (div_cnt == brp);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      div_cnt <= '0;
      tq_tick <= 1'b0;
    end else begin
      tq_tick <= adv;
      div_cnt <= adv ? '0 : div_cnt + 1'b1;
    end
  end

  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> !tq_tick);
endmodule

// File: rtl/can_resync_limiter.sv
module can_resync_limiter #(
  parameter int RJW_W = 2,
  parameter int ERR_W = 5,
  localparam int ADJ_W = RJW_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hold,
  input  logic [RJW_W-1:0]        rjw,
  input  logic                    req,
  input  logic signed [ERR_W-1:0] err,
  input  logic                    in_ph2,
  input  logic                    bit_done,
  output logic [ADJ_W-1:0]        ext,
  output logic [ADJ_W-1:0]        shrt
);
  logic             used;
  logic [ADJ_W-1:0] lim;
  logic [ERR_W-1:0] mag;
  logic [ADJ_W-1:0] capped;
  logic             neg;

  assign lim    = ADJ_W'(rjw) + 1'b1;
  assign neg    = err[ERR_W-1];
  assign mag    = neg ? ERR_W'(-err) : ERR_W'(err);
  assign capped = (mag > ERR_W'(lim)) ? lim : mag[ADJ_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || hold || bit_done) begin
      used <= 1'b0;
      ext  <= '0;
      shrt <= '0;
    end else if (req && !used && (err != '0)) begin
      if (neg) begin
        shrt <= capped;
        used <= 1'b1;
      end else if (!in_ph2) begin
        ext  <= capped;
        used <= 1'b1;
      end
    end
  end

  // R5
  ext_cap_chk: assert property (@(posedge clk) disable iff (rst)
    ext <= lim);
  // R6
  shrt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    shrt <= lim);
endmodule

// File: rtl/can_seg_sequencer.sv
module can_seg_sequencer
  import can_bt_pkg::*;
#(
  parameter int BS1_W = 4,
  parameter int BS2_W = 3,
  parameter int ADJ_W = 3,
  localparam int MAXW = (BS1_W > BS2_W) ? BS1_W : BS2_W,
  localparam int QW   = MAXW + ADJ_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             adv,
  input  logic [BS1_W-1:0] bs1,
  input  logic [BS2_W-1:0] bs2,
  input  logic [ADJ_W-1:0] ext,
  input  logic [ADJ_W-1:0] shrt,
  output logic             in_ph2,
  output logic             bit_done,
  output logic             sample_tick,
  output logic             bit_tick
);
  seg_e          st;
  logic [QW-1:0] qcnt;
  logic [QW-1:0] ph1_last;
  logic          ph1_done;

  assign ph1_last = QW'(bs1) + QW'(ext);
  assign ph1_done = adv && (st == SEG_PH1) && (qcnt >= ph1_last);
  assign bit_done = adv && (st == SEG_PH2) && ((qcnt + QW'(shrt)) >= QW'(bs2));
  assign in_ph2   = (st == SEG_PH2);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      st          <= SEG_SYNC;
      qcnt        <= '0;
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else begin
      sample_tick <= ph1_done;
      bit_tick    <= bit_done;
      if (adv) begin
        case (st)
          SEG_SYNC: begin
            st   <= SEG_PH1;
            qcnt <= '0;
          end
          SEG_PH1: begin
            if (ph1_done) begin
              st   <= SEG_PH2;
              qcnt <= '0;
            end else begin
              qcnt <= qcnt + 1'b1;
            end
          end
          SEG_PH2: begin
            if (bit_done) begin
              st   <= SEG_SYNC;
              qcnt <= '0;
            end else begin
              qcnt <= qcnt + 1'b1;
            end
          end
          default: begin
            st   <= SEG_SYNC;
            qcnt <= '0;
          end
        endcase
      end
    end
  end

  // R10
  tick_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sample_tick && bit_tick));
  // R6
  bit_gap_chk: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick);
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 6,
  parameter int RJW_W = 2,
  parameter int BS1_W = 4,
  parameter int BS2_W = 3,
  parameter int ERR_W = 5,
  localparam int CFG_W = RJW_W + BRP_W,
  localparam int ADJ_W = RJW_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    standby,
  input  logic                    cfg_we,
  input  logic                    cfg_sel,
  input  logic [CFG_W-1:0]        cfg_wdata,
  input  logic                    resync_req,
  input  logic signed [ERR_W-1:0] resync_err,
  output logic                    tq_tick,
  output logic                    sample_tick,
  output logic                    bit_tick
);
  logic [CFG_W-1:0]         presc_q;
  logic [BS1_W+BS2_W-1:0]   seg_q;
  logic                     adv;
  logic                     in_ph2;
  logic                     bit_done;
  logic [ADJ_W-1:0]         ext;
  logic [ADJ_W-1:0]         shrt;

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= '0;
      seg_q   <= '0;
    end else if (cfg_we && standby) begin
      if (cfg_sel) seg_q   <= cfg_wdata[BS1_W+BS2_W-1:0];
      else         presc_q <= cfg_wdata;
    end
  end

  can_tq_prescaler #(.BRP_W(BRP_W)) u_presc (
    .clk(clk), .rst(rst), .hold(standby),
    .brp(presc_q[BRP_W-1:0]), .adv(adv), .tq_tick(tq_tick)
  );

  can_resync_limiter #(.RJW_W(RJW_W), .ERR_W(ERR_W)) u_lim (
    .clk(clk), .rst(rst), .hold(standby),
    .rjw(presc_q[CFG_W-1:BRP_W]), .req(resync_req), .err(resync_err),
    .in_ph2(in_ph2), .bit_done(bit_done), .ext(ext), .shrt(shrt)
  );

  can_seg_sequencer #(.BS1_W(BS1_W), .BS2_W(BS2_W), .ADJ_W(ADJ_W)) u_seq (
    .clk(clk), .rst(rst), .hold(standby), .adv(adv),
    .bs1(seg_q[BS1_W-1:0]), .bs2(seg_q[BS1_W+BS2_W-1:BS1_W]),
    .ext(ext), .shrt(shrt), .in_ph2(in_ph2), .bit_done(bit_done),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  // R8
  locked_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !standby) |=> ($stable(presc_q) && $stable(seg_q)));
  // R10
  bit_on_tq_chk: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> tq_tick);
endmodule

// File: tb/tb_can_bit_timer.sv
`timescale 1ns/1ps
module tb_can_bit_timer;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              standby = 1'b1;
  logic              cfg_we = 1'b0;
  logic              cfg_sel = 1'b0;
  logic [7:0]        cfg_wdata = '0;
  logic              resync_req = 1'b0;
  logic signed [4:0] resync_err = '0;
  logic              tq_tick, sample_tick, bit_tick;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  can_bit_timer dut (
    .clk(clk), .rst(rst), .standby(standby), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .resync_req(resync_req),
    .resync_err(resync_err), .tq_tick(tq_tick),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Measures one bit period starting at the current negedge (n = 0).
  task automatic run_bit(input int at1, input int e1, input int at2, input int e2,
                         output int len, output int samp, output int ntq);
    int n = 0;
    len = -1; samp = -1; ntq = 0;
    while (len < 0 && n < 3000) begin
      resync_req = (n == at1) || (n == at2);
      resync_err = (n == at2) ? 5'(e2) : 5'(e1);
      @(negedge clk);
      n++;
      resync_req = 1'b0;
      if (tq_tick) ntq++;
      if (sample_tick && samp < 0) samp = n;
      if (bit_tick) len = n;
    end
  endtask

  task automatic setup(input int brp, input int rjw, input int bs1, input int bs2);
    standby = 1'b1;
    @(negedge clk);
    wr(1'b0, 8'((rjw << 6) | brp));
    wr(1'b1, 8'((bs2 << 4) | bs1));
    standby = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    fails++; tests++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int len, samp, ntq, p, l, lim, exp2;
    int brps[3] = '{0, 1, 3};
    int b1s[3]  = '{0, 2, 5};
    int b2s[3]  = '{0, 1, 3};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 strobes low", int'(tq_tick | sample_tick | bit_tick), 0);
    standby = 1'b0;
    run_bit(-1, 0, -1, 0, len, samp, ntq);
    chk("R1 default bit length", len, 3);
    chk("R1 default sample", samp, 2);

    // Sweep of divider and segment lengths
    foreach (brps[i]) foreach (b1s[j]) foreach (b2s[k]) begin
      setup(brps[i], 0, b1s[j], b2s[k]);
      p = brps[i] + 1; l = b1s[j] + b2s[k] + 3;
      run_bit(-1, 0, -1, 0, len, samp, ntq);
      chk("R9 first bit after release", len, l * p);
      chk("R4 sample point", samp, (b1s[j] + 2) * p);
      chk("R2 quanta per bit", ntq, l);
      run_bit(-1, 0, -1, 0, len, samp, ntq);
      chk("R3 bit period", len, l * p);
    end

    // Resynchronization: BRP=1, RJW=1 (limit 2), BS1=3, BS2=3, L=9
    setup(1, 1, 3, 3);
    p = 2; l = 9; lim = 2;
    run_bit(-1, 0, -1, 0, len, samp, ntq);
    run_bit(0, 1, -1, 0, len, samp, ntq);
    chk("R5 +1 length", len, (l + 1) * p);
    chk("R5 +1 sample", samp, (5 + 1) * p);
    run_bit(-1, 0, -1, 0, len, samp, ntq);
    chk("R5 no carry-over", len, l * p);
    run_bit(0, 7, -1, 0, len, samp, ntq);
    chk("R5 capped length", len, (l + lim) * p);
    chk("R5 capped sample", samp, (5 + lim) * p);
    run_bit(0, -1, -1, 0, len, samp, ntq);
    chk("R6 -1 length", len, (l - 1) * p);
    chk("R6 -1 sample", samp, 5 * p);
    run_bit(0, -6, -1, 0, len, samp, ntq);
    chk("R6 capped length", len, (l - lim) * p);
    run_bit(0, 1, 3, 2, len, samp, ntq);
    chk("R7 second request ignored", len, (l + 1) * p);
    run_bit(0, 0, 3, 2, len, samp, ntq);
    chk("R7 zero error leaves first slot", len, (l + 2) * p);
    run_bit(0, -1, 4, 2, len, samp, ntq);
    chk("R7 later positive ignored", len, (l - 1) * p);

    // Floor of phase 2: BRP=0, RJW=3 (limit 4), BS1=2, BS2=3
    setup(0, 3, 2, 3);
    run_bit(-1, 0, -1, 0, len, samp, ntq);
    run_bit(0, -16, -1, 0, len, samp, ntq);
    exp2 = 1 + 3 + 1;
    chk("R6 phase 2 floor", len, exp2);
    run_bit(0, -2, -1, 0, len, samp, ntq);
    chk("R6 partial trim", len, 8 - 2);

    // R8: writes while running are ignored
    setup(1, 0, 2, 1);
    run_bit(-1, 0, -1, 0, len, samp, ntq);
    wr(1'b0, 8'h05);
    wr(1'b1, 8'h77);
    run_bit(-1, 0, -1, 0, len, samp, ntq);
    run_bit(-1, 0, -1, 0, len, samp, ntq);
    chk("R8 period unchanged", len, 6 * 2);
    chk("R8 sample unchanged", samp, 4 * 2);

    // R9: standby mid-bit silences strobes and restarts timing
    repeat (3) @(negedge clk);
    standby = 1'b1;
    begin
      int seen = 0;
      repeat (10) begin
        @(negedge clk);
        if (tq_tick | sample_tick | bit_tick) seen++;
      end
      chk("R9 quiet in standby", seen, 0);
    end
    standby = 1'b0;
    run_bit(-1, 0, -1, 0, len, samp, ntq);
    chk("R9 restart at sync", len, 6 * 2);

    // R10: strobe relations over a few bits
    begin
      int bad = 0;
      repeat (60) begin
        @(negedge clk);
        if (bit_tick && !tq_tick) bad++;
        if (bit_tick && sample_tick) bad++;
      end
      chk("R10 strobe relation", bad, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule